// File: doc/BRIEF.md
# Dual Digital Potentiometer Serial Command Controller

This block is the digital control core of a two-channel, 256-position digital potentiometer. A host talks to it over a three-wire serial port: an active-low select, a serial clock and one data line. The data line is split at the block boundary into an input, an output and an output enable, and the pad logic merges them. The serial pins are brought into the system clock domain through two-stage synchronisers. All edges are detected there, so the serial clock must run well below the system clock.

Each channel has a live wiper register that drives the tap selection and a retained shadow register that stands in for the non-volatile cell. Frames of 8 or 16 bits carry commands. Writes place a new tap position in a wiper or in a shadow register. Copies move a value between a channel's wiper and its shadow. Reads return either register on the data line. A shadow update holds a busy flag for a fixed number of system clocks. When the general reset is released, each wiper takes the value of its shadow register. The shadow registers are cleared only by the separate power-on reset.

Top module: `dpot_ctrl`

## Requirements
- R1: After power-on reset the shadow registers hold NV_INIT_A and NV_INIT_B. Once both resets are released, the wipers show those values, the data output enable is low and the busy flag is low.
- R2: A 16-bit frame whose first byte is 0x10 (channel A) or 0x11 (channel B) loads the second byte into that wiper. Bit 0 of the control byte selects the channel. The wiper stays unchanged until select goes high.
- R3: A frame executes only when exactly 8 or 16 serial clock rising edges arrived while select was low. Any other count leaves every register unchanged.
- R4: A 16-bit frame with first byte 0x20/0x21 writes the second byte to shadow A/B and leaves the wiper alone. The busy flag goes high for exactly BUSY_CYCLES system clocks, and the shadow takes the new value when busy ends.
- R5: The 8-bit command 0x30/0x31 copies wiper A/B into its shadow, with the same busy behaviour as R4. The 8-bit command 0x40/0x41 copies shadow A/B into the wiper.
- R6: An 8-bit command may be sent as a 16-bit frame. The command then sits in the second byte, and a first byte that is not a write code (upper nibble 0001 or 0010) has no effect.
- R7: Command 0x50/0x51 reads wiper A/B and 0x60/0x61 reads shadow A/B. On the falling serial clock edge that follows the last command bit, the output enable rises and the MSB is driven. Each later falling edge shifts out the next bit.
- R8: The output enable falls on the second falling serial clock edge after the one that shifted out the last data bit, or as soon as select goes high. A read frame executes nothing when select goes high.
- R9: While busy is high, every command, including reads, is discarded.
- R10: Undefined control bytes are ignored. These are upper nibbles other than 1 to 6, any set bit among bits 3..1, and a write code sent in an 8-bit frame.
- R11: Releasing the general reset alone (power-on reset held high) reloads each wiper from its current shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | General active-low reset; wipers reload from shadows on release |
| por_n | input | 1 | Power-on active-low reset of the shadow registers |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial read data toward the host |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| wiper_a | output | 8 | Tap position of channel A |
| wiper_b | output | 8 | Tap position of channel B |
| nv_busy | output | 1 | Shadow register update in progress |

## Verification
A wrong bit count or frame capture appears on the wiper outputs a few system clocks after select rises, so each write is checked right there. An error in the shadow path does not show on the wipers. It is brought out through a read frame, or through a reset reload, at the next access. Errors in the readback shifter or the standby counter show on the data output and its enable within one serial clock period. The bench therefore samples the output enable before and after the standby edge. A wrong busy length is seen as a miscount of the cycles with busy high, measured against the exact parameter.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int WIPER_W   = 8;
    localparam int SHORT_LEN = WIPER_W;
    localparam int LONG_LEN  = 2 * WIPER_W;

    typedef enum logic [3:0] {
        OP_NONE     = 4'h0,
        OP_WR_WIPER = 4'h1,
        OP_WR_NV    = 4'h2,
        OP_W_TO_NV  = 4'h3,
        OP_NV_TO_W  = 4'h4,
        OP_RD_WIPER = 4'h5,
        OP_RD_NV    = 4'h6
    } dpot_op_e;

    // Operation nibble of a control byte; bits 3..1 must be clear.
    function automatic logic [3:0] ctl_op(input logic [WIPER_W-1:0] b);
        return (b[3:1] == 3'b000) ? b[7:4] : OP_NONE;
    endfunction

    function automatic logic is_write_op(input logic [3:0] op);
        return (op == OP_WR_WIPER) || (op == OP_WR_NV);
    endfunction

    function automatic logic is_read_op(input logic [3:0] op);
        return (op == OP_RD_WIPER) || (op == OP_RD_NV);
    endfunction

endpackage

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx
    import dpot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    input  logic                busy_i,
    input  logic [WIPER_W-1:0]  rd_byte_i,
    output logic [1:0]          rd_sel_o,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic                cmd_valid_o,
    output logic                cmd_len16_o,
    output logic [LONG_LEN-1:0] cmd_frame_o
);

    localparam int CNT_SAT  = LONG_LEN + 1;
    localparam int CNT_W    = $clog2(LONG_LEN + 2);
    localparam int OUT_STOP = WIPER_W + 1;
    localparam int OCNT_W   = $clog2(WIPER_W + 2);

    typedef struct packed {
        logic [2:0]          cs_p;
        logic [2:0]          sck_p;
        logic [1:0]          sdi_p;
        logic [CNT_W-1:0]    cnt;
        logic [LONG_LEN-1:0] sh;
        logic                rd_seen;
        logic                oe;
        logic [WIPER_W-1:0]  osh;
        logic [OCNT_W-1:0]   ocnt;
        logic                cmd_v;
        logic                len16;
        logic [LONG_LEN-1:0] frame;
    } rx_t;

    rx_t rx_d, rx_q;

    logic cs_hi, cs_rise, cs_fall, sck_rise, sck_fall, sdi;
    logic len_ok, rd_go;
    logic [3:0] lo_op, hi_op;

    assign cs_hi    = rx_q.cs_p[1];
    assign cs_rise  = rx_q.cs_p[1] & ~rx_q.cs_p[2];
    assign cs_fall  = ~rx_q.cs_p[1] & rx_q.cs_p[2];
    assign sck_rise = rx_q.sck_p[1] & ~rx_q.sck_p[2];
    assign sck_fall = ~rx_q.sck_p[1] & rx_q.sck_p[2];
    assign sdi      = rx_q.sdi_p[1];
    assign lo_op    = ctl_op(rx_q.sh[WIPER_W-1:0]);
    assign hi_op    = ctl_op(rx_q.sh[LONG_LEN-1:WIPER_W]);
    assign len_ok   = (rx_q.cnt == CNT_W'(SHORT_LEN)) || (rx_q.cnt == CNT_W'(LONG_LEN));
    assign rd_go    = !cs_hi && sck_fall && !rx_q.oe && !rx_q.rd_seen && !busy_i
                      && is_read_op(lo_op)
                      && ((rx_q.cnt == CNT_W'(SHORT_LEN))
                          || ((rx_q.cnt == CNT_W'(LONG_LEN)) && !is_write_op(hi_op)));
    assign rd_sel_o = {lo_op == OP_RD_NV, rx_q.sh[0]};

    always_comb begin
        rx_d       = rx_q;
        rx_d.cs_p  = {rx_q.cs_p[1:0], cs_n_i};
        rx_d.sck_p = {rx_q.sck_p[1:0], sclk_i};
        rx_d.sdi_p = {rx_q.sdi_p[0], sdi_i};
        rx_d.cmd_v = 1'b0;

        if (cs_fall) begin
            rx_d.cnt     = '0;
            rx_d.sh      = '0;
            rx_d.rd_seen = 1'b0;
        end else if (!cs_hi && sck_rise) begin
            rx_d.sh = {rx_q.sh[LONG_LEN-2:0], sdi};
            if (rx_q.cnt != CNT_W'(CNT_SAT)) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end

        if (rd_go) begin
            rx_d.oe      = 1'b1;
            rx_d.rd_seen = 1'b1;
            rx_d.osh     = rd_byte_i;
            rx_d.ocnt    = '0;
        end else if (rx_q.oe && sck_fall) begin
            rx_d.ocnt = rx_q.ocnt + 1'b1;
            rx_d.osh  = {rx_q.osh[WIPER_W-2:0], 1'b0};
            if (rx_q.ocnt + 1'b1 == OCNT_W'(OUT_STOP)) begin
                rx_d.oe = 1'b0;
            end
        end

        if (cs_rise) begin
            rx_d.oe = 1'b0;
            if (!rx_q.rd_seen && len_ok) begin
                rx_d.cmd_v = 1'b1;
                rx_d.len16 = (rx_q.cnt == CNT_W'(LONG_LEN));
                rx_d.frame = rx_q.sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.cs_p <= 3'b111;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sdo_o       = rx_q.oe & rx_q.osh[WIPER_W-1];
    assign sdo_oe_o    = rx_q.oe;
    assign cmd_valid_o = rx_q.cmd_v;
    assign cmd_len16_o = rx_q.len16;
    assign cmd_frame_o = rx_q.frame;

    // R8: the line is never driven once select has been high for a cycle
    p_oe_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.cs_p[1] && rx_q.cs_p[2]) |-> !rx_q.oe);

    // R7: driving starts only right after a complete command byte
    p_oe_starts_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_q.oe) |-> ((rx_q.cnt == CNT_W'(SHORT_LEN)) || (rx_q.cnt == CNT_W'(LONG_LEN))));

    // R3: a command pulse follows a select release with a legal count
    p_exec_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.cmd_v |-> (rx_q.cs_p[2] && !rx_q.rd_seen
                        && ((rx_q.cnt == CNT_W'(SHORT_LEN)) || (rx_q.cnt == CNT_W'(LONG_LEN)))));

endmodule

// File: rtl/dpot_exec.sv
module dpot_exec
    import dpot_pkg::*;
#(
    parameter int                 BUSY_CYCLES = 1000,
    parameter logic [WIPER_W-1:0] NV_INIT_A   = 8'h80,
    parameter logic [WIPER_W-1:0] NV_INIT_B   = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic                cmd_valid_i,
    input  logic                cmd_len16_i,
    input  logic [LONG_LEN-1:0] cmd_frame_i,
    input  logic [1:0]          rd_sel_i,
    output logic [WIPER_W-1:0]  rd_byte_o,
    output logic [WIPER_W-1:0]  wiper_a_o,
    output logic [WIPER_W-1:0]  wiper_b_o,
    output logic                busy_o
);

    localparam int BC_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic               load;
        logic [WIPER_W-1:0] wa;
        logic [WIPER_W-1:0] wb;
        logic               busy;
        logic [BC_W-1:0]    bcnt;
        logic               psel;
        logic [WIPER_W-1:0] pdata;
    } ex_t;

    typedef struct packed {
        logic [WIPER_W-1:0] na;
        logic [WIPER_W-1:0] nb;
    } nv_t;

    ex_t ex_d, ex_q;
    nv_t nv_d, nv_q;

    logic [3:0]         hi_op, lo_op, op;
    logic               sel;
    logic [WIPER_W-1:0] dat;

    assign hi_op = ctl_op(cmd_frame_i[LONG_LEN-1:WIPER_W]);
    assign lo_op = ctl_op(cmd_frame_i[WIPER_W-1:0]);
    assign dat   = cmd_frame_i[WIPER_W-1:0];

    always_comb begin
        if (cmd_len16_i && is_write_op(hi_op)) begin
            op  = hi_op;
            sel = cmd_frame_i[WIPER_W];
        end else begin
            op  = is_write_op(lo_op) ? OP_NONE : lo_op;
            sel = cmd_frame_i[0];
        end
    end

    always_comb begin
        ex_d      = ex_q;
        nv_d      = nv_q;
        ex_d.load = 1'b0;

        if (ex_q.load) begin
            ex_d.wa = nv_q.na;
            ex_d.wb = nv_q.nb;
        end

        if (ex_q.busy) begin
            if (ex_q.bcnt == '0) begin
                ex_d.busy = 1'b0;
                if (ex_q.psel) nv_d.nb = ex_q.pdata;
                else           nv_d.na = ex_q.pdata;
            end else begin
                ex_d.bcnt = ex_q.bcnt - 1'b1;
            end
        end else if (cmd_valid_i && !ex_q.load) begin
            case (op)
                OP_WR_WIPER: begin
                    if (sel) ex_d.wb = dat;
                    else     ex_d.wa = dat;
                end
                OP_WR_NV, OP_W_TO_NV: begin
                    ex_d.busy  = 1'b1;
                    ex_d.bcnt  = BC_W'(BUSY_CYCLES - 1);
                    ex_d.psel  = sel;
                    ex_d.pdata = (op == OP_WR_NV) ? dat : (sel ? ex_q.wb : ex_q.wa);
                end
                OP_NV_TO_W: begin
                    if (sel) ex_d.wb = nv_q.nb;
                    else     ex_d.wa = nv_q.na;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q      <= '0;
            ex_q.load <= 1'b1;
        end else begin
            ex_q <= ex_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            nv_q.na <= NV_INIT_A;
            nv_q.nb <= NV_INIT_B;
        end else if (rst_n) begin
            nv_q <= nv_d;
        end
    end

    always_comb begin
        case (rd_sel_i)
            2'b00:   rd_byte_o = ex_q.wa;
            2'b01:   rd_byte_o = ex_q.wb;
            2'b10:   rd_byte_o = nv_q.na;
            default: rd_byte_o = nv_q.nb;
        endcase
    end

    assign wiper_a_o = ex_q.wa;
    assign wiper_b_o = ex_q.wb;
    assign busy_o    = ex_q.busy;

    // R9: a command landing in a busy window changes nothing
    p_drop_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (cmd_valid_i && ex_q.busy && ex_q.bcnt != '0)
        |=> ($stable(ex_q.wa) && $stable(ex_q.wb) && $stable(nv_q)));

    // R2: wipers move only on a command or the reload cycle
    p_wiper_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!cmd_valid_i && !ex_q.load) |=> ($stable(ex_q.wa) && $stable(ex_q.wb)));

    // R4: shadow contents change only at the end of a busy window
    p_nv_at_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(ex_q.busy && ex_q.bcnt == '0) |=> $stable(nv_q));

    // R11: after the reload cycle the wipers equal the shadows
    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $fell(ex_q.load) |-> (ex_q.wa == nv_q.na && ex_q.wb == nv_q.nb));

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int                 BUSY_CYCLES = 1000,
    parameter logic [WIPER_W-1:0] NV_INIT_A   = 8'h80,
    parameter logic [WIPER_W-1:0] NV_INIT_B   = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdio_in,
    output logic               sdio_out,
    output logic               sdio_oe,
    output logic [WIPER_W-1:0] wiper_a,
    output logic [WIPER_W-1:0] wiper_b,
    output logic               nv_busy
);

    logic                cmd_valid;
    logic                cmd_len16;
    logic [LONG_LEN-1:0] cmd_frame;
    logic [1:0]          rd_sel;
    logic [WIPER_W-1:0]  rd_byte;

    dpot_serial_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n),
        .sclk_i      (sclk),
        .sdi_i       (sdio_in),
        .busy_i      (nv_busy),
        .rd_byte_i   (rd_byte),
        .rd_sel_o    (rd_sel),
        .sdo_o       (sdio_out),
        .sdo_oe_o    (sdio_oe),
        .cmd_valid_o (cmd_valid),
        .cmd_len16_o (cmd_len16),
        .cmd_frame_o (cmd_frame)
    );

    dpot_exec #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .NV_INIT_A   (NV_INIT_A),
        .NV_INIT_B   (NV_INIT_B)
    ) u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .cmd_valid_i (cmd_valid),
        .cmd_len16_i (cmd_len16),
        .cmd_frame_i (cmd_frame),
        .rd_sel_i    (rd_sel),
        .rd_byte_o   (rd_byte),
        .wiper_a_o   (wiper_a),
        .wiper_b_o   (wiper_b),
        .busy_o      (nv_busy)
    );

endmodule

// File: tb/dpot_ctrl_tb.sv
module dpot_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int BUSY       = 400;
    localparam logic [7:0] INIT_A = 8'h80;
    localparam logic [7:0] INIT_B = 8'h3C;

    logic clk = 1'b0;
    logic rst_n, por_n, cs_n, sclk, sdio_in;
    logic sdio_out, sdio_oe, nv_busy;
    logic [7:0] wiper_a, wiper_b;

    int n_chk = 0;
    int n_fail = 0;
    int busy_hi = 0;
    bit done = 1'b0;
    logic [7:0] ew_a, ew_b, en_a, en_b, b;

    dpot_ctrl #(.BUSY_CYCLES(BUSY), .NV_INIT_A(INIT_A), .NV_INIT_B(INIT_B)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cs_n(cs_n), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .wiper_a(wiper_a), .wiper_b(wiper_b), .nv_busy(nv_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (nv_busy) busy_hi++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic shift_in(input int n, input logic [31:0] v);
        cs_n = 1'b0;
        tick(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdio_in = v[i];
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        sdio_in = 1'b0;
    endtask

    task automatic read_out(input int k, output logic [7:0] r);
        r = '0;
        for (int i = 0; i < k; i++) begin
            tick(HALF);
            r = {r[6:0], sdio_out};
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic close_frame();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic frame(input int n, input logic [31:0] v);
        shift_in(n, v);
        close_frame();
    endtask

    task automatic rd(input logic [7:0] code, output logic [7:0] r);
        shift_in(8, {24'h0, code});
        read_out(8, r);
        close_frame();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * BUSY && nv_busy; i++) tick(1);
    endtask

    task automatic wipers(input string req);
        check(req, wiper_a, ew_a);
        check(req, wiper_b, ew_b);
    endtask

    task automatic shadows(input string req);
        rd(8'h60, b); check(req, b, en_a);
        rd(8'h61, b); check(req, b, en_b);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdio_in = 1'b0;
        tick(5);
        por_n = 1'b1; rst_n = 1'b1;
        tick(5);
        // R1: power-up state
        ew_a = INIT_A; ew_b = INIT_B; en_a = INIT_A; en_b = INIT_B;
        wipers("R1");
        check("R1 oe", sdio_oe, 0);
        check("R1 busy", nv_busy, 0);

        // R2: sweep of every tap on A, stride on B
        for (int v = 0; v < 256; v++) begin
            frame(16, 32'h1000 | v);
            ew_a = 8'(v);
            wipers("R2 sweep A");
        end
        for (int v = 0; v < 256; v += 7) begin
            frame(16, 32'h1100 | v);
            ew_b = 8'(v);
            wipers("R2 sweep B");
        end
        // R2: no change before select release
        shift_in(16, 32'h1022);
        tick(2 * HALF);
        check("R2 before release", wiper_a, ew_a);
        close_frame();
        ew_a = 8'h22;
        check("R2 after release", wiper_a, ew_a);

        // R3: illegal bit counts
        frame(15, 32'h1055);
        frame(17, 32'h08055);
        frame(7, 32'h40);
        frame(9, 32'h141);
        frame(24, 32'h001166);
        wipers("R3");

        // R4: shadow write with exact busy length
        busy_hi = 0;
        frame(16, 32'h20A5);
        check("R4 wiper untouched", wiper_a, ew_a);
        check("R4 busy high", nv_busy, 1);
        wait_idle();
        check("R4 busy length", busy_hi, BUSY);
        en_a = 8'hA5;
        shadows("R4 shadow");

        // R9: commands dropped while busy
        frame(16, 32'h2166);
        frame(16, 32'h1011);
        check("R9 busy still", nv_busy, 1);
        wait_idle();
        en_b = 8'h66;
        wipers("R9 dropped");
        shadows("R9 shadow");

        // R5: copies both ways
        frame(8, 32'h30);
        wait_idle();
        en_a = ew_a;
        shadows("R5 wiper to shadow");
        frame(16, 32'h1077); ew_a = 8'h77;
        frame(8, 32'h41);    ew_b = en_b;
        wipers("R5 shadow to wiper B");
        frame(8, 32'h40);    ew_a = en_a;
        wipers("R5 shadow to wiper A");

        // R6: padded forms
        frame(16, 32'h1105); ew_b = 8'h05;
        frame(16, 32'h0041); ew_b = en_b;
        wipers("R6 padded copy");
        frame(16, 32'h1001); ew_a = 8'h01;
        frame(16, 32'hC340); ew_a = en_a;
        wipers("R6 junk pad");
        shift_in(16, 32'h0051);
        read_out(8, b);
        close_frame();
        check("R6 padded read", b, ew_b);

        // R7: reads of each register
        frame(16, 32'h10C3); ew_a = 8'hC3;
        rd(8'h50, b); check("R7 read wiper A", b, ew_a);
        rd(8'h51, b); check("R7 read wiper B", b, ew_b);
        rd(8'h60, b); check("R7 read shadow A", b, en_a);
        shift_in(8, 32'h50);
        tick(HALF);
        check("R7 oe after command", sdio_oe, 1);
        read_out(8, b);
        close_frame();
        wipers("R8 read executes nothing");

        // R8: standby point and early release
        shift_in(8, 32'h51);
        read_out(8, b);
        tick(HALF);
        check("R8 oe before standby", sdio_oe, 1);
        sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
        check("R8 oe at standby", sdio_oe, 0);
        close_frame();
        shift_in(8, 32'h50);
        read_out(3, b);
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
        check("R8 oe on select high", sdio_oe, 0);
        check("R8 partial bits", b, int'(ew_a[7:5]));

        // R10: undefined codes
        frame(16, 32'h7012);
        frame(8, 32'h00);
        frame(8, 32'hF1);
        frame(8, 32'h10);
        frame(8, 32'h32);
        shift_in(8, 32'h52);
        read_out(2, b);
        check("R10 no drive on bad read", sdio_oe, 0);
        close_frame();
        check("R10 busy", nv_busy, 0);
        wipers("R10");
        shadows("R10 shadow");

        // R11: general reset reloads wipers
        frame(16, 32'h1099);
        frame(16, 32'h1198);
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5);
        ew_a = en_a; ew_b = en_b;
        wipers("R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule